// File: doc/BRIEF.md
# Multi-Tap Video Stream Formatter

This block turns a raster of 10-bit sensor samples into a parallel multi-tap video stream of the kind a frame grabber receives. On every clock it presents one word per tap, a frame-valid flag and a line-valid flag. A tap word means something only while both flags are high. A two-bit mode select chooses one of three formats: four taps with full 10-bit samples, four taps reduced to 8 bits, or eight taps reduced to 8 bits. In the 8-bit formats the two least significant bits of each sample are discarded.

The sample source hands over a beat of up to eight consecutive pixels of a line through a ready/valid handshake. Lane 0 holds the leftmost pixel. In four-tap formats only lanes 0 to 3 are used. A frame-start pulse launches one frame. The frame is sent line by line from the top-left pixel to the bottom-right pixel. The line-valid pulse of each line lasts width divided by tap count cycles. A programmable horizontal gap separates lines, and frame-valid frames the whole image with one idle cycle on each side. Mode, width, height and gap are sampled only between frames. If the source runs dry in the middle of a line, the block pauses without losing or repeating a pixel.

Top module: `vid_tap_formatter`

## Requirements
- R1: Mode code 0 selects four taps at 10 bits. Code 3 behaves as code 0. Tap k occupies `tap_data[10k+9:10k]` and carries source lane k unchanged. Taps 4 to 7 read zero.
- R2: Mode code 1 (four taps) and mode code 2 (eight taps) carry lane bits [9:2] in tap bits [7:0], with tap bits [9:8] zero.
- R3: Mode code 2 drives all eight taps. Each line-valid pulse lasts width/8 cycles in mode 2 and width/4 cycles in the four-tap modes. A full 2352-pixel line takes 294 cycles.
- R4: While line-valid is low, including during reset, every tap reads zero.
- R5: With an uninterrupted source, frame-valid rises exactly one cycle before the first line-valid of a frame. It falls exactly one cycle after the last line-valid cycle. Line-valid is never high while frame-valid is low.
- R6: With an uninterrupted source, line-valid stays low between two lines of a frame for exactly the programmed gap. A gap of 0 acts as 1.
- R7: One frame carries exactly height lines, and a total of width×height pixels in raster order.
- R8: Mode, width, height and gap are sampled only while no frame is in progress. A change made during a frame leaves that frame unchanged and applies from the next frame.
- R9: A cycle in which the source is not valid while the block is ready produces a line-valid-low cycle. The line then resumes at the next pixel.
- R10: `pix_ready` is high only while a line is being sent. A beat accepted on one clock edge appears on the outputs right after the next edge.
- R11: A frame-start pulse that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all outputs launch on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Output format: 0 four taps 10 bit, 1 four taps 8 bit, 2 eight taps 8 bit, 3 as 0 |
| frame_start | input | 1 | Pulse that starts one frame when idle |
| img_width | input | 12 | Pixels per line; a multiple of the active tap count |
| img_height | input | 11 | Lines per frame |
| line_gap | input | 8 | Line-valid low cycles between lines (0 treated as 1) |
| pix_data | input | 80 | Up to eight consecutive 10-bit samples, lane 0 leftmost |
| pix_valid | input | 1 | Source beat valid |
| pix_ready | output | 1 | Block accepts a beat this cycle |
| tap_data | output | 80 | Eight 10-bit tap words, tap k at bits [10k+9:10k] |
| fval | output | 1 | Frame valid |
| lval | output | 1 | Line valid |

## Verification
Two events can fall on the same clock: a request for a new format, new geometry or a new frame start, and the frame already running. The bench raises such a request a few cycles into a frame. It does this by changing the mode and width together and pulsing frame start. It then judges every beat of that frame against the old format and counts frame-valid cycles after the frame to confirm nothing restarted. The next frame is checked in the new format. A second pairing is a source stall landing on the last beat of a line. The stall frames cycle the source every third clock so that stalls land on line ends and gaps. Every line-valid cycle is compared with the handshake seen one edge earlier, and the stream is compared pixel by pixel.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

  typedef enum logic [1:0] {
    MODE_4T10 = 2'd0,
    MODE_4T8  = 2'd1,
    MODE_8T8  = 2'd2,
    MODE_RSVD = 2'd3
  } vtf_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_LINE = 3'd2,
    ST_GAP  = 3'd3,
    ST_TAIL = 3'd4
  } vtf_state_e;

  function automatic logic mode_is_wide(vtf_mode_e m);
    return m == MODE_8T8;
  endfunction

  function automatic logic mode_is_narrow(vtf_mode_e m);
    return (m == MODE_4T8) || (m == MODE_8T8);
  endfunction

endpackage

// File: rtl/vtf_cfg_hold.sv
module vtf_cfg_hold
  import vtf_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int WW   = 12,
  parameter int HW   = 11,
  parameter int BW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic [1:0]    mode_req,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] height,
  input  logic [BW-1:0] gap_req,
  output vtf_mode_e     mode_q,
  output logic [WW-1:0] cpl_q,
  output logic [HW-1:0] rows_q,
  output logic [BW-1:0] gap_q
);

  localparam int SH_WIDE = $clog2(TAPS);
  localparam int SH_HALF = $clog2(TAPS / 2);
  localparam logic [BW-1:0] GAP_MIN = BW'(1);

  vtf_mode_e     mode_d;
  logic [WW-1:0] cpl_d;
  logic [BW-1:0] gap_d;
  logic          load_en;

  assign load_en = idle;

  always_comb begin
    mode_d = (vtf_mode_e'(mode_req) == MODE_RSVD) ? MODE_4T10 : vtf_mode_e'(mode_req);
    cpl_d  = mode_is_wide(mode_d) ? (width >> SH_WIDE) : (width >> SH_HALF);
    gap_d  = (gap_req == '0) ? GAP_MIN : gap_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_4T10;
      cpl_q  <= '0;
      rows_q <= '0;
      gap_q  <= GAP_MIN;
    end else if (load_en) begin
      mode_q <= mode_d;
      cpl_q  <= cpl_d;
      rows_q <= height;
      gap_q  <= gap_d;
    end
  end

  // R6: the held gap is never zero
  p_gap_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q != '0);

endmodule

// File: rtl/vtf_raster_ctl.sv
module vtf_raster_ctl
  import vtf_pkg::*;
#(
  parameter int WW = 12,
  parameter int HW = 11,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic [WW-1:0] cpl,
  input  logic [HW-1:0] rows,
  input  logic [BW-1:0] gap,
  output logic          idle,
  output logic          pix_ready,
  output logic          xfer,
  output logic          in_frame
);

  localparam logic [WW-1:0] COL_ONE = WW'(1);
  localparam logic [HW-1:0] ROW_ONE = HW'(1);
  localparam logic [BW-1:0] GAP_ONE = BW'(1);

  vtf_state_e    state_q, state_d;
  logic [WW-1:0] col_q, col_d;
  logic [HW-1:0] row_q, row_d;
  logic [BW-1:0] gcnt_q, gcnt_d;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    gcnt_d  = gcnt_q;
    case (state_q)
      ST_IDLE: begin
        if (frame_start) state_d = ST_LEAD;
      end
      ST_LEAD: begin
        col_d   = '0;
        row_d   = '0;
        state_d = ((cpl == '0) || (rows == '0)) ? ST_TAIL : ST_LINE;
      end
      ST_LINE: begin
        if (pix_valid) begin
          if (col_q == cpl - COL_ONE) begin
            col_d = '0;
            if (row_q == rows - ROW_ONE) begin
              state_d = ST_TAIL;
            end else begin
              row_d   = row_q + ROW_ONE;
              gcnt_d  = gap;
              state_d = ST_GAP;
            end
          end else begin
            col_d = col_q + COL_ONE;
          end
        end
      end
      ST_GAP: begin
        if (gcnt_q <= GAP_ONE) state_d = ST_LINE;
        else gcnt_d = gcnt_q - GAP_ONE;
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      row_q   <= row_d;
      gcnt_q  <= gcnt_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign in_frame  = !idle;
  assign pix_ready = (state_q == ST_LINE);
  assign xfer      = pix_ready && pix_valid;

  // R3: column index stays inside the line
  p_col_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINE) |-> (col_q < cpl));

  // R7: row index stays inside the frame
  p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LINE) || (state_q == ST_GAP)) |-> (row_q < rows));

  // R5: the lead-in lasts a single cycle
  p_lead_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD) |=> ((state_q == ST_LINE) || (state_q == ST_TAIL)));

endmodule

// File: rtl/vtf_tap_pack.sv
module vtf_tap_pack
  import vtf_pkg::*;
#(
  parameter int TAPS     = 8,
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer,
  input  logic                  in_frame,
  input  vtf_mode_e             mode,
  input  logic [TAPS*PIX_W-1:0] pix_data,
  output logic [TAPS*PIX_W-1:0] tap_data,
  output logic                  fval,
  output logic                  lval
);

  localparam int HALF = TAPS / 2;
  localparam int DROP = PIX_W - NARROW_W;

  logic [PIX_W-1:0] tap_d [TAPS];
  logic [PIX_W-1:0] tap_q [TAPS];
  logic             fval_q, lval_q;
  logic             wide, narrow, tap_en;

  assign wide   = mode_is_wide(mode);
  assign narrow = mode_is_narrow(mode);
  assign tap_en = xfer || lval_q;

  for (genvar i = 0; i < TAPS; i++) begin : g_lane
    logic [PIX_W-1:0] smp;
    logic             active;
    assign smp    = pix_data[i*PIX_W +: PIX_W];
    assign active = (i < HALF) || wide;

    always_comb begin
      if (xfer && active)
        tap_d[i] = narrow ? {{DROP{1'b0}}, smp[PIX_W-1:DROP]} : smp;
      else
        tap_d[i] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[i] <= '0;
      else if (tap_en) tap_q[i] <= tap_d[i];
    end

    assign tap_data[i*PIX_W +: PIX_W] = tap_q[i];

    // R2: reduced-depth words keep their top bits clear
    p_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lval_q && narrow) |-> (tap_q[i][PIX_W-1 -: DROP] == '0));

    if (i >= HALF) begin : g_upper
      // R1: upper taps are silent in four-tap formats
      p_upper_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lval_q && !wide) |-> (tap_q[i] == '0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fval_q <= 1'b0;
      lval_q <= 1'b0;
    end else begin
      fval_q <= in_frame;
      lval_q <= xfer;
    end
  end

  assign fval = fval_q;
  assign lval = lval_q;

  // R4: no data outside line-valid
  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lval_q |-> (tap_data == '0));

  // R5: line-valid nested in frame-valid
  p_lval_in_fval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lval_q |-> fval_q);

  // R5: frame-valid already high the cycle before a line starts
  p_fval_leads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lval_q) |-> $past(fval_q));

endmodule

// File: rtl/vid_tap_formatter.sv
module vid_tap_formatter
  import vtf_pkg::*;
#(
  parameter int TAPS     = 8,
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8,
  parameter int WW       = 12,
  parameter int HW       = 11,
  parameter int BW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode_sel,
  input  logic                  frame_start,
  input  logic [WW-1:0]         img_width,
  input  logic [HW-1:0]         img_height,
  input  logic [BW-1:0]         line_gap,
  input  logic [TAPS*PIX_W-1:0] pix_data,
  input  logic                  pix_valid,
  output logic                  pix_ready,
  output logic [TAPS*PIX_W-1:0] tap_data,
  output logic                  fval,
  output logic                  lval
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_i;
  logic          idle, xfer, in_frame;
  vtf_mode_e     mode_q;
  logic [WW-1:0] cpl;
  logic [HW-1:0] rows;
  logic [BW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  vtf_cfg_hold #(.TAPS(TAPS), .WW(WW), .HW(HW), .BW(BW)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .idle(idle), .mode_req(mode_sel),
    .width(img_width), .height(img_height), .gap_req(line_gap),
    .mode_q(mode_q), .cpl_q(cpl), .rows_q(rows), .gap_q(gap)
  );

  vtf_raster_ctl #(.WW(WW), .HW(HW), .BW(BW)) u_ctl (
    .clk(clk), .rst_n(rst_n_i), .frame_start(frame_start), .pix_valid(pix_valid),
    .cpl(cpl), .rows(rows), .gap(gap), .idle(idle), .pix_ready(pix_ready),
    .xfer(xfer), .in_frame(in_frame)
  );

  vtf_tap_pack #(.TAPS(TAPS), .PIX_W(PIX_W), .NARROW_W(NARROW_W)) u_pack (
    .clk(clk), .rst_n(rst_n_i), .xfer(xfer), .in_frame(in_frame), .mode(mode_q),
    .pix_data(pix_data), .tap_data(tap_data), .fval(fval), .lval(lval)
  );

  // R8: the format in force cannot move while frame-valid stays high
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fval && $past(fval)) |-> $stable(mode_q));

  // R9: a starved ready cycle yields a line-valid-low cycle
  p_stall_gap_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pix_ready && !pix_valid) |=> !lval);

  // R10: ready only inside the frame
  p_ready_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    pix_ready |=> fval);

endmodule

// File: tb/vid_tap_formatter_test.sv
module vid_tap_formatter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        frame_start;
  logic [11:0] img_width;
  logic [10:0] img_height;
  logic [7:0]  line_gap;
  logic [79:0] pix_data;
  logic        pix_valid;
  logic        pix_ready;
  logic [79:0] tap_data;
  logic        fval, lval;

  vid_tap_formatter uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_start(frame_start),
    .img_width(img_width), .img_height(img_height), .line_gap(line_gap),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .tap_data(tap_data), .fval(fval), .lval(lval)
  );

  always #4 clk = ~clk;

  // columns: mode, width, height, gap, stall, expected beats per line, expected gap
  localparam int NVEC = 7;
  localparam int TBL [NVEC][7] = '{
    '{0,   16, 3, 2, 0,   4, 2},
    '{1,   12, 2, 1, 0,   3, 1},
    '{2,   32, 4, 3, 0,   4, 3},
    '{2, 2352, 2, 0, 0, 294, 1},
    '{3,    8, 2, 1, 0,   2, 1},
    '{0,   20, 3, 4, 1,   5, 4},
    '{2,   24, 3, 2, 1,   3, 2}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int  cur_mode, cur_taps, exp_cpl, seed, cyc;
  bit  stall_on, mon_on, prev_xfer;
  int  src_idx, out_idx;
  int  bad_lat, bad_data, bad_zero, bad_runs;
  int  beats, lines, lead, run, gap_run, min_gap, max_gap, tail_run, tail_final;
  bit  in_seen, prev_l, prev_f;

  function automatic logic [9:0] smp(int p, int s);
    return 10'((p * 37 + s * 101 + 3) & 1023);
  endfunction

  function automatic logic [79:0] exp_beat(int base, int md, int s);
    logic [79:0] v = '0;
    int taps = (md == 2) ? 8 : 4;
    for (int t = 0; t < taps; t++) begin
      logic [9:0] x = smp(base + t, s);
      v[t*10 +: 10] = ((md == 1) || (md == 2)) ? {2'b00, x[9:2]} : x;
    end
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int got, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (lval !== prev_xfer) bad_lat++;
      if (lval) begin
        if (tap_data !== exp_beat(out_idx, cur_mode, seed)) bad_data++;
        out_idx += cur_taps;
        beats++;
      end else if (tap_data !== '0) bad_zero++;
      if (fval && !in_seen && !lval) lead++;
      if (lval) begin
        if (!prev_l) begin
          if (in_seen) begin
            if (gap_run < min_gap) min_gap = gap_run;
            if (gap_run > max_gap) max_gap = gap_run;
          end
          lines++;
          run = 0;
          gap_run = 0;
        end
        run++;
        in_seen = 1;
        tail_run = 0;
      end else begin
        if (prev_l && run != exp_cpl) bad_runs++;
        if (in_seen) gap_run++;
        if (fval && in_seen) tail_run++;
      end
      if (prev_f && !fval) tail_final = tail_run;
      prev_l = lval;
      prev_f = fval;
    end
    if (prev_xfer) src_idx += cur_taps;
    pix_valid = stall_on ? ((cyc % 3) != 0) : 1'b1;
    for (int t = 0; t < 8; t++) pix_data[t*10 +: 10] = smp(src_idx + t, seed);
    prev_xfer = pix_valid && pix_ready && mon_on;
  end

  task automatic run_frame(int md, int w, int h, int hb, int st, int ecpl, int egap, bit mid);
    int norm = (md == 3) ? 0 : md;
    string dtag;
    mode_sel   = 2'(md);
    img_width  = 12'(w);
    img_height = 11'(h);
    line_gap   = 8'(hb);
    @(negedge clk);
    cur_mode = norm; cur_taps = (norm == 2) ? 8 : 4; exp_cpl = ecpl;
    stall_on = st[0]; seed++;
    src_idx = 0; out_idx = 0;
    bad_lat = 0; bad_data = 0; bad_zero = 0; bad_runs = 0;
    beats = 0; lines = 0; lead = 0; run = 0; gap_run = 0;
    min_gap = 1000000; max_gap = 0; tail_run = 0; tail_final = -1;
    in_seen = 0; prev_l = 0; prev_f = 0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (!fval) @(negedge clk);
    if (mid) begin
      repeat (3) @(negedge clk);
      mode_sel    = (norm == 0) ? 2'd2 : 2'd0;
      img_width   = 12'd40;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    while (fval) @(negedge clk);
    repeat (2) @(negedge clk);
    dtag = (norm == 0) ? "R1 pixel stream" : "R2 pixel stream";
    if (mid) dtag = "R8 old format kept";
    chk(beats == ecpl * h, "R7 beat total", beats, ecpl * h);
    chk(bad_data == 0, dtag, bad_data, 0);
    chk(bad_zero == 0, "R4 idle taps zero", bad_zero, 0);
    chk(bad_lat == 0, st ? "R9 stall handling" : "R10 one-cycle latency", bad_lat, 0);
    if (!st) begin
      chk(lines == h, "R7 line count", lines, h);
      chk(bad_runs == 0, "R3 line length", bad_runs, 0);
      chk(lead == 1, "R5 frame lead", lead, 1);
      chk(tail_final == 1, "R5 frame tail", tail_final, 1);
      if (h > 1) begin
        chk(min_gap == egap, "R6 min gap", min_gap, egap);
        chk(max_gap == egap, "R6 max gap", max_gap, egap);
      end
    end
  endtask

  initial begin
    int waited;
    for (waited = 0; waited < 150000 && !finished; waited++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", waited, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int highs;
    rst_n = 1'b0; mode_sel = '0; frame_start = 1'b0;
    img_width = 12'd16; img_height = 11'd2; line_gap = 8'd1;
    mon_on = 0; stall_on = 0; prev_xfer = 0; cur_taps = 4; seed = 0; cyc = 0;
    src_idx = 0; out_idx = 0;
    repeat (3) @(negedge clk);
    // R4: reset state at the ports
    chk(fval === 1'b0 && lval === 1'b0, "R4 reset flags", int'(fval) + int'(lval), 0);
    chk(tap_data === '0, "R4 reset taps", int'(tap_data[31:0]), 0);
    chk(pix_ready === 1'b0, "R10 reset ready", int'(pix_ready), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;
    chk(pix_ready === 1'b0 && fval === 1'b0, "R10 idle ready", int'(pix_ready), 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5], TBL[v][6], 1'b0);

    // R8 and R11: format change and frame start during a frame
    run_frame(0, 16, 2, 1, 0, 4, 1, 1'b1);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (fval) highs++;
    end
    chk(highs == 0, "R11 busy start ignored", highs, 0);
    // R8: held request applies to the next frame (mode 2, width 40)
    run_frame(2, 40, 2, 1, 0, 5, 1, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule